// File: doc/BRIEF.md
# Windowed Watchdog Timer with Early Warning

This block is a supervision timer that software must service inside a time window. A 7-bit down-counter runs from a slow tick. The tick is the bus clock divided by a fixed base ratio and then by a programmable power of two. A reset request is raised in three cases:

- software lets the counter run down until bit 6 clears;
- software refreshes the counter while it is still above the programmed window value;
- software loads a value that already has bit 6 clear.

Refreshes are therefore legal only in a band between the window value and the timeout threshold. An early-warning flag is raised one step before the timeout, so a handler can act before the reset request fires.

Software reaches three registers through a single write strobe, an address and a combinational read port. The enable bit and the early-warning interrupt enable bit can be set by software but never cleared by it. Only a reset of the block clears them. The reset request output is a one-cycle pulse. Distributing the system reset is left to the surrounding logic.

Top module: `win_watchdog`

## Requirements
- R1: After reset the control register reads 0x007F (enable 0, counter 0x7F), the configuration register reads 0x007F (window 0x7F, prescaler 0, interrupt enable 0), the status register reads 0, and `rst_req` and `irq` are 0.
- R2: The counter steps down by one every BASE_DIV × 2^P clock cycles, where P is configuration bits 10:8. A write to the control register restarts this period, so the first step comes exactly BASE_DIV × 2^P cycles after the write edge.
- R3: While enabled, a step from 0x40 to 0x3F raises `rst_req` for exactly one cycle, starting on the edge that stores 0x3F.
- R4: A control write whose counter field (bits 6:0) has bit 6 clear raises a one-cycle `rst_req` on the write edge if the watchdog is enabled or the same write enables it. The written value is still loaded.
- R5: A control write made while the watchdog is enabled and the current counter is above the window (configuration bits 6:0) raises a one-cycle `rst_req`. A write made when the counter is at or below the window raises none.
- R6: Control bit 7 is the enable. Writing 1 sets it. Writing 0 leaves it set, and only reset clears it.
- R7: While disabled, the counter keeps stepping and wraps from 0 to 0x7F, but `rst_req` never rises.
- R8: The status flag (status bit 0) is set on the step that brings the counter to 0x40, whether or not the interrupt is enabled and whether or not the watchdog is enabled.
- R9: A status write with bit 0 equal to 0 clears the flag. A status write with bit 0 equal to 1 leaves it unchanged.
- R10: Configuration bit 12 is the interrupt enable. It is set by writing 1 and cannot be cleared by a write. `irq` is high exactly while the flag and this enable are both 1.
- R11: The register addresses are 0 for control, 1 for configuration and 2 for status. Reads return the current register value through `rdata` combinationally. All unused bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| addr | input | 2 | Register select for both reads and writes |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for the register selected by `addr` |
| irq | output | 1 | Early-warning interrupt |
| rst_req | output | 1 | One-cycle reset request pulse |

## Verification
A corrupted counter shows up on the control read port after one tick period at most, and a wrong divider shows up as a step that comes one cycle early or late. Both are caught because samples are taken on the cycle just before and the cycle just after the expected step. A wrong window compare or threshold compare shows up as a pulse that is missing or extra, on the very edge of the offending write or step. The sticky bits, and the flag's priority of setting over clearing, are read back right after the writes that must not disturb them.

// File: rtl/wwd_pkg.sv
`timescale 1ns/100ps
package wwd_pkg;
    localparam int CNT_W  = 7;
    localparam int PSC_W  = 3;
    localparam int DATA_W = 16;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_CFG  = 2'd1;
    localparam logic [1:0] A_STAT = 2'd2;

    localparam int CTRL_EN_BIT = 7;
    localparam int CFG_PSC_LO  = 8;
    localparam int CFG_IE_BIT  = 12;

    typedef struct packed {
        logic             en;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] win;
        logic [PSC_W-1:0] psc;
        logic             ie;
        logic             flag;
        logic             rst_req;
    } wwd_state_t;
endpackage

// File: rtl/wwd_tick_gen.sv
`timescale 1ns/100ps
module wwd_tick_gen #(
    parameter int BASE_DIV = 4096,
    parameter int PSC_W    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PSC_W-1:0] psc,
    input  logic             restart,
    output logic             tick
);
    localparam int DIV_W = $clog2(BASE_DIV) + (1 << PSC_W);

    logic [DIV_W-1:0] div_d, div_q;
    logic [DIV_W-1:0] limit;

    always_comb begin
        limit = DIV_W'(BASE_DIV) << psc;
        tick  = (div_q == limit - DIV_W'(1));
        if (restart || tick) div_d = '0;
        else                 div_d = div_q + DIV_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    // Divider stays inside the selected period once it has restarted.
    p_div_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (div_q < limit));
endmodule

// File: rtl/wwd_ctrl.sv
`timescale 1ns/100ps
module wwd_ctrl
    import wwd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              tick,
    output logic              restart,
    output logic [PSC_W-1:0]  psc,
    output logic [DATA_W-1:0] rdata,
    output logic              irq,
    output logic              rst_req
);
    localparam logic [CNT_W-1:0] THR = CNT_W'(1) << (CNT_W - 1);

    wwd_state_t s_d, s_q;
    logic wr_ctrl, wr_cfg, wr_stat, en_next;

    always_comb begin
        wr_ctrl = wr_en && (addr == A_CTRL);
        wr_cfg  = wr_en && (addr == A_CFG);
        wr_stat = wr_en && (addr == A_STAT);
        en_next = s_q.en | wdata[CTRL_EN_BIT];

        s_d         = s_q;
        s_d.rst_req = 1'b0;

        if (wr_stat && !wdata[0]) s_d.flag = 1'b0;

        if (wr_cfg) begin
            s_d.win = wdata[CNT_W-1:0];
            s_d.psc = wdata[CFG_PSC_LO +: PSC_W];
            s_d.ie  = s_q.ie | wdata[CFG_IE_BIT];
        end

        if (wr_ctrl) begin
            s_d.en  = en_next;
            s_d.cnt = wdata[CNT_W-1:0];
            if (en_next && !wdata[CNT_W-1])     s_d.rst_req = 1'b1;
            if (s_q.en && (s_q.cnt > s_q.win))  s_d.rst_req = 1'b1;
        end else if (tick) begin
            s_d.cnt = s_q.cnt - CNT_W'(1);
            if (s_q.cnt == THR + CNT_W'(1)) s_d.flag = 1'b1;
            if (s_q.en && (s_q.cnt == THR)) s_d.rst_req = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.en      <= 1'b0;
            s_q.cnt     <= '1;
            s_q.win     <= '1;
            s_q.psc     <= '0;
            s_q.ie      <= 1'b0;
            s_q.flag    <= 1'b0;
            s_q.rst_req <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        restart = wr_ctrl;
        psc     = s_q.psc;
        irq     = s_q.flag & s_q.ie;
        rst_req = s_q.rst_req;
        rdata   = '0;
        case (addr)
            A_CTRL: begin
                rdata[CNT_W-1:0]   = s_q.cnt;
                rdata[CTRL_EN_BIT] = s_q.en;
            end
            A_CFG: begin
                rdata[CNT_W-1:0]              = s_q.win;
                rdata[CFG_PSC_LO +: PSC_W]    = s_q.psc;
                rdata[CFG_IE_BIT]             = s_q.ie;
            end
            A_STAT:  rdata[0] = s_q.flag;
            default: rdata = '0;
        endcase
    end

    p_tick_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_ctrl) |=> (s_q.cnt == $past(s_q.cnt) - CNT_W'(1)));
    p_timeout_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_ctrl && s_q.en && s_q.cnt == THR) |=> rst_req);
    p_en_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.en |=> s_q.en);
    p_no_req_disabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> s_q.en);
    p_flag_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_ctrl && s_q.cnt == THR + CNT_W'(1)) |=> s_q.flag);
    p_ie_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.ie |=> s_q.ie);
endmodule

// File: rtl/win_watchdog.sv
`timescale 1ns/100ps
module win_watchdog #(
    parameter int BASE_DIV = 4096
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [1:0]  addr,
    input  logic [15:0] wdata,
    output logic [15:0] rdata,
    output logic        irq,
    output logic        rst_req
);
    import wwd_pkg::*;

    logic                tick, restart;
    logic [PSC_W-1:0]    psc;

    wwd_tick_gen #(.BASE_DIV(BASE_DIV), .PSC_W(PSC_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .psc(psc), .restart(restart), .tick(tick)
    );

    wwd_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .tick(tick), .restart(restart), .psc(psc), .rdata(rdata),
        .irq(irq), .rst_req(rst_req)
    );
endmodule

// File: tb/sim_win_watchdog.sv
`timescale 1ns/100ps
module sim_win_watchdog;
    localparam int BD = 4;

    logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [15:0] wdata = 16'd0;
    logic [15:0] rdata;
    logic irq, rst_req;
    int n_chk = 0, n_bad = 0, pulses = 0;
    bit done = 1'b0;

    win_watchdog #(.BASE_DIV(BD)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .irq(irq), .rst_req(rst_req)
    );

    always #2 clk = ~clk;
    always @(negedge clk) if (rst_n && rst_req) pulses++;

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] v);
        addr = a; #0.2; v = rdata;
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk); #1;
        wr_en = 1'b0; wdata = 16'd0;
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    function automatic logic [15:0] cfg(input logic [6:0] w, input logic [2:0] p, input logic ie);
        return {3'b0, ie, 1'b0, p, 1'b0, w};
    endfunction

    task automatic do_reset();
        rst_n = 1'b0; wr_en = 1'b0;
        edges(3);
        rst_n = 1'b1;
        edges(1);
    endtask

    task automatic t_reset();
        logic [15:0] v;
        rd(2'd0, v); chk("R1 ctrl", v, 16'h007F);
        rd(2'd1, v); chk("R1 cfg", v, 16'h007F);
        rd(2'd2, v); chk("R1 stat", v, 16'h0000);
        chk("R1 rst_req/irq", {14'd0, rst_req, irq}, 16'd0);
    endtask

    task automatic t_enable_rate();
        logic [15:0] v;
        wr(2'd0, 16'h00FF);
        rd(2'd0, v); chk("R11 ctrl readback", v, 16'h00FF);
        edges(3); rd(2'd0, v); chk("R2 before step", v, 16'h00FF);
        edges(1); rd(2'd0, v); chk("R2 step P=0", v, 16'h00FE);
    endtask

    task automatic t_prescale();
        logic [15:0] v;
        wr(2'd1, cfg(7'h7F, 3'd2, 1'b0));
        rd(2'd1, v); chk("R11 cfg readback", v, 16'h027F);
        wr(2'd0, 16'h00FF);
        edges(15); rd(2'd0, v); chk("R2 P=2 before step", v, 16'h00FF);
        edges(1);  rd(2'd0, v); chk("R2 P=2 step", v, 16'h00FE);
        wr(2'd1, cfg(7'h7F, 3'd0, 1'b0));
    endtask

    task automatic t_en_sticky();
        logic [15:0] v;
        int p0 = pulses;
        wr(2'd0, 16'h007F);
        rd(2'd0, v); chk("R6 enable stays set", v, 16'h00FF);
        edges(1); chk("R6 no pulse", 16'(pulses - p0), 16'd0);
    endtask

    task automatic t_early();
        logic [15:0] v;
        wr(2'd1, cfg(7'h50, 3'd0, 1'b0));
        wr(2'd0, 16'h00FF);
        chk("R5 early refresh pulse", {15'd0, rst_req}, 16'd1);
        rd(2'd0, v); chk("R5 value loaded", v, 16'h00FF);
        edges(1); chk("R5 pulse one cycle", {15'd0, rst_req}, 16'd0);
    endtask

    task automatic t_legal();
        logic [15:0] v;
        int p0;
        wr(2'd0, 16'h00FF);
        p0 = pulses + 1;
        edges(188); rd(2'd0, v); chk("R5 reached window", v, 16'h00D0);
        wr(2'd0, 16'h00FF);
        edges(2); chk("R5 legal refresh no pulse", 16'(pulses - p0), 16'd0);
        rd(2'd0, v); chk("R5 legal refresh value", v, 16'h00FF);
    endtask

    task automatic t_low_write();
        logic [15:0] v;
        wr(2'd1, cfg(7'h7F, 3'd0, 1'b0));
        wr(2'd0, 16'h00B0);
        chk("R4 low write pulse", {15'd0, rst_req}, 16'd1);
        rd(2'd0, v); chk("R4 value loaded", v, 16'h00B0);
        edges(1); chk("R4 pulse one cycle", {15'd0, rst_req}, 16'd0);
    endtask

    task automatic t_timeout();
        logic [15:0] v;
        wr(2'd1, cfg(7'h7F, 3'd0, 1'b1));
        wr(2'd0, 16'h00C2);
        edges(7); rd(2'd2, v); chk("R8 flag not yet", {v[14:0], irq}, 16'd0);
        edges(1); rd(2'd2, v); chk("R8 flag at 0x40", v, 16'h0001);
        chk("R10 irq high", {15'd0, irq}, 16'd1);
        rd(2'd0, v); chk("R8 counter 0x40", v, 16'h00C0);
        edges(3); chk("R3 no pulse before timeout", {15'd0, rst_req}, 16'd0);
        edges(1); chk("R3 timeout pulse", {15'd0, rst_req}, 16'd1);
        rd(2'd0, v); chk("R3 counter 0x3F", v, 16'h00BF);
        edges(1); chk("R3 pulse one cycle", {15'd0, rst_req}, 16'd0);
    endtask

    task automatic t_flag_clear();
        logic [15:0] v;
        wr(2'd2, 16'h0001);
        rd(2'd2, v); chk("R9 write 1 keeps flag", v, 16'h0001);
        wr(2'd2, 16'h0000);
        rd(2'd2, v); chk("R9 write 0 clears flag", v, 16'h0000);
        chk("R10 irq low after clear", {15'd0, irq}, 16'd0);
        wr(2'd1, cfg(7'h7F, 3'd0, 1'b0));
        rd(2'd1, v); chk("R10 ie stays set", v, 16'h107F);
    endtask

    task automatic t_disabled();
        logic [15:0] v;
        int p0 = pulses;
        wr(2'd0, 16'h0010);
        edges(1); chk("R7 low write disabled no pulse", 16'(pulses - p0), 16'd0);
        wr(2'd0, 16'h0041);
        edges(4); rd(2'd2, v); chk("R8 flag while disabled", v, 16'h0001);
        chk("R10 irq masked", {15'd0, irq}, 16'd0);
        edges(5); rd(2'd0, v); chk("R7 counter runs", v, 16'h003F);
        chk("R7 no timeout pulse", 16'(pulses - p0), 16'd0);
    endtask

    initial begin
        do_reset();
        t_reset();
        t_enable_rate();
        t_prescale();
        t_en_sticky();
        t_early();
        t_legal();
        t_low_write();
        t_timeout();
        t_flag_clear();
        do_reset();
        t_reset();
        t_disabled();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule